// File: doc/BRIEF.md
# Timer Tick Gate and Prescaler

This block produces the tick enables that drive a small bank of timers: eight general timer channels, one operating-system timer channel and one watchdog channel. For each channel it picks one of three single-cycle tick sources (peripheral, slow real-time, external). It divides the chosen tick by a power of four and gates the result with a per-channel stop flag. The result is one tick-enable pulse per channel, in the system clock domain.

Software controls the block through a simple synchronous register bus with address, write data, write strobe and read data. Stop flags are never written directly. A write-one-to-set register stops channels, a write-one-to-clear register starts them, and a status register shows all stop flags. Each channel has a 16-bit control register holding the source select and the prescale code. That register only accepts writes while its channel is running.

Top module: `tick_gate_unit`

Address map (word addresses on `bus_addr`): 0 = stop status (read), 1 = stop set (write), 2 = stop clear (write), 8 + c = control of channel c. Channels 0 to 7 are the timers, channel 8 is the OS timer and channel 9 is the watchdog.

## Requirements
- R1: After reset every stop flag reads 1, so status reads 0x180FF. Every control register reads 0 and every tick output is low.
- R2: A write to the set register (address 1) sets each stop flag whose bit is 1 in the write data. Flags whose bit is 0 keep their value.
- R3: A write to the clear register (address 2) clears each stop flag whose bit is 1 in the write data. Flags whose bit is 0 keep their value.
- R4: A write to a control register (address 8 + channel) stores write-data bits 15:0 only while that channel's stop flag is 0. While the flag is 1 the write is ignored and the old value stays.
- R5: Control bits 2:0 select the source one-hot: bit 0 peripheral, bit 1 real-time, bit 2 external. When several bits are set, the lowest set bit wins. When none is set, the channel never pulses.
- R6: Control bits 5:3 hold a prescale code p. The channel emits one pulse per 4^p selected ticks, so codes 0 to 5 divide by 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 also divide by 1024.
- R7: The division count restarts from zero whenever the channel is stopped or its control register is written. After a restart, the first pulse follows the full ratio of new ticks.
- R8: Read data appears one cycle after the address is presented. Addresses 1, 2 and any unmapped address read 0.
- R9: Stop flags sit at status bits 0 to 7 (timers 0 to 7), bit 15 (OS timer) and bit 16 (watchdog). Set or clear bits at any other position change nothing.
- R10: A tick output is a single-cycle pulse, registered one cycle after the source tick that completes the ratio. It only appears if the channel was running in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| tick_periph | input | 1 | Peripheral tick source (single-cycle enable) |
| tick_rtc | input | 1 | Slow real-time tick source |
| tick_ext | input | 1 | External tick source |
| tick_out | output | 10 | Per-channel divided tick enables (8 = OS timer, 9 = watchdog) |

## Verification
- **Stop flags:** a wrong flag is visible on the next status read, one cycle after the address. It also shows at once as a missing or stray pulse on that channel's tick output.
- **Division counter:** a counter that fails to clear on stop or control write only shows on the first pulse after restart. That pulse arrives early, up to one full ratio (1024 ticks) sooner than expected, so the bench counts pulses across restart points.
- **Control register:** a write that slips past the stop gate shows on the next readback of that control register.

// File: rtl/tgu_pkg.sv
package tgu_pkg;
  localparam int CTL_W   = 16;
  localparam int SEL_W   = 3;
  localparam int PS_LSB  = 3;
  localparam int PS_W    = 3;
  localparam int CNT_W   = 10;
  localparam int STAT_W  = 17;
  localparam int OS_POS  = 15;
  localparam int WDT_POS = 16;
  localparam int PS_MAX  = 5;

  localparam int A_STAT = 0;
  localparam int A_SET  = 1;
  localparam int A_CLR  = 2;
  localparam int A_CTL0 = 8;

  typedef enum logic [1:0] {SRC_NONE, SRC_PERIPH, SRC_RTC, SRC_EXT} src_e;

  // lowest set select bit wins; no bit means no source
  function automatic src_e pick_src(input logic [SEL_W-1:0] sel);
    if (sel[0])      return SRC_PERIPH;
    else if (sel[1]) return SRC_RTC;
    else if (sel[2]) return SRC_EXT;
    else             return SRC_NONE;
  endfunction

  // terminal count of the division counter for a prescale code
  function automatic logic [CNT_W-1:0] wrap_at(input logic [PS_W-1:0] code);
    if (int'(code) >= PS_MAX) return '1;
    else return CNT_W'((1 << (2 * int'(code))) - 1);
  endfunction

  // stop-flag bit position of a channel index
  function automatic int stop_pos(input int ch, input int ntmr);
    if (ch < ntmr)       return ch;
    else if (ch == ntmr) return OS_POS;
    else                 return WDT_POS;
  endfunction
endpackage

// File: rtl/tgu_rst_sync.sv
module tgu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_core_n = sync_q;
endmodule

// File: rtl/tgu_regs.sv
module tgu_regs
  import tgu_pkg::*;
#(
  parameter int NUM_TMR = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int NCH    = NUM_TMR + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NCH-1:0]       stop_vec,
  output logic [NCH-1:0]       ctl_wr,
  output logic [NCH*CTL_W-1:0] ctl_flat,
  output logic [STAT_W-1:0]    status_vec
);
  logic [NCH-1:0]    stop_q, stop_d;
  logic [NCH-1:0]    set_hit, clr_hit, ctl_hit;
  logic [CTL_W-1:0]  ctl_q [NCH];
  logic [CTL_W-1:0]  ctl_d [NCH];
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              wr_set, wr_clr;

  assign wr_set = bus_we && (bus_addr == ADDR_W'(A_SET));
  assign wr_clr = bus_we && (bus_addr == ADDR_W'(A_CLR));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int POS = stop_pos(g, NUM_TMR);
    assign set_hit[g] = wr_set & bus_wdata[POS];
    assign clr_hit[g] = wr_clr & bus_wdata[POS];
    assign ctl_hit[g] = bus_we && (bus_addr == ADDR_W'(A_CTL0 + g));
    assign ctl_wr[g]  = ctl_hit[g] & ~stop_q[g];
    assign ctl_d[g]   = ctl_wr[g] ? bus_wdata[CTL_W-1:0] : ctl_q[g];
    assign ctl_flat[g*CTL_W +: CTL_W] = ctl_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctl_q[g] <= '0;
      else if (ctl_wr[g])  ctl_q[g] <= ctl_d[g];
    end
  end

  assign stop_d = (stop_q | set_hit) & ~clr_hit;

  always_comb begin
    status_vec = '0;
    for (int c = 0; c < NCH; c++) status_vec[stop_pos(c, NUM_TMR)] = stop_q[c];
  end

  always_comb begin
    rdata_d = '0;
    if (bus_addr == ADDR_W'(A_STAT)) rdata_d = DATA_W'(status_vec);
    for (int c = 0; c < NCH; c++)
      if (bus_addr == ADDR_W'(A_CTL0 + c)) rdata_d = DATA_W'(ctl_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= '1;
      rdata_q <= '0;
    end else begin
      stop_q  <= stop_d;
      rdata_q <= rdata_d;
    end
  end

  assign stop_vec  = stop_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/tgu_chan.sv
module tgu_chan
  import tgu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ctl_wr,
  input  logic [SEL_W-1:0] sel,
  input  logic [PS_W-1:0]  ps_code,
  input  logic             tick_periph,
  input  logic             tick_rtc,
  input  logic             tick_ext,
  output logic             tick_out
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             src_tick, adv, wrap;

  always_comb begin
    unique case (pick_src(sel))
      SRC_PERIPH: src_tick = tick_periph;
      SRC_RTC:    src_tick = tick_rtc;
      SRC_EXT:    src_tick = tick_ext;
      default:    src_tick = 1'b0;
    endcase
  end

  assign wrap = (cnt_q == wrap_at(ps_code));
  assign adv  = run & src_tick & ~ctl_wr;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || ctl_wr) cnt_d = '0;
    else if (adv)       cnt_d = wrap ? '0 : cnt_q + 1'b1;
    pulse_d = adv & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign tick_out = pulse_q;
endmodule

// File: rtl/tick_gate_unit.sv
module tick_gate_unit
  import tgu_pkg::*;
#(
  parameter int NUM_TMR = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int NCH    = NUM_TMR + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_periph,
  input  logic              tick_rtc,
  input  logic              tick_ext,
  output logic [NCH-1:0]    tick_out
);
  logic                 rst_core_n;
  logic [NCH-1:0]       stop_vec;
  logic [NCH-1:0]       ctl_wr;
  logic [NCH*CTL_W-1:0] ctl_flat;
  logic [STAT_W-1:0]    status_vec;

  tgu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tgu_regs #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .stop_vec   (stop_vec),
    .ctl_wr     (ctl_wr),
    .ctl_flat   (ctl_flat),
    .status_vec (status_vec)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tgu_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .run         (~stop_vec[g]),
      .ctl_wr      (ctl_wr[g]),
      .sel         (ctl_flat[g*CTL_W +: SEL_W]),
      .ps_code     (ctl_flat[g*CTL_W + PS_LSB +: PS_W]),
      .tick_periph (tick_periph),
      .tick_rtc    (tick_rtc),
      .tick_ext    (tick_ext),
      .tick_out    (tick_out[g])
    );
  end
endmodule

// File: rtl/tgu_checker.sv
module tgu_checker
  import tgu_pkg::*;
#(
  parameter int NUM_TMR = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int NCH    = NUM_TMR + 2
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 bus_we,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NCH-1:0]       tick_out,
  input logic [NCH-1:0]       stop_vec,
  input logic [NCH*CTL_W-1:0] ctl_flat,
  input logic [STAT_W-1:0]    status_vec
);
  a_r8_status_readback: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(rst_core_n) && $past(bus_addr == ADDR_W'(A_STAT))
      |-> bus_rdata == DATA_W'($past(status_vec)));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    localparam int POS = stop_pos(g, NUM_TMR);

    a_r2_set_stops: assert property (@(posedge clk) disable iff (!rst_core_n)
      $past(rst_core_n) && $past(bus_we && bus_addr == ADDR_W'(A_SET) && bus_wdata[POS])
        |-> stop_vec[g]);

    a_r3_clear_starts: assert property (@(posedge clk) disable iff (!rst_core_n)
      $past(rst_core_n) && $past(bus_we && bus_addr == ADDR_W'(A_CLR) && bus_wdata[POS])
        |-> !stop_vec[g]);

    a_r4_ctl_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_core_n)
      $past(stop_vec[g]) |-> $stable(ctl_flat[g*CTL_W +: CTL_W]));

    a_r5_no_source_no_tick: assert property (@(posedge clk) disable iff (!rst_core_n)
      $past(ctl_flat[g*CTL_W +: SEL_W] == '0) |-> !tick_out[g]);

    a_r10_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_core_n)
      tick_out[g] |-> $past(!stop_vec[g]));
  end
endmodule

bind tick_gate_unit tgu_checker #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tgu_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .tick_out   (tick_out),
  .stop_vec   (stop_vec),
  .ctl_flat   (ctl_flat),
  .status_vec (status_vec)
);

// File: tb/tick_gate_unit_tb_top.sv
`timescale 1ns/1ps
module tick_gate_unit_tb_top;
  localparam int NCH = 10;

  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        tick_periph, tick_rtc, tick_ext;
  logic [9:0]  tick_out;

  int n_checks;
  int n_fail;
  int cyc;

  tick_gate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_periph(tick_periph),
    .tick_rtc(tick_rtc), .tick_ext(tick_ext), .tick_out(tick_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {channel[3:0], select[2:0], prescale[2:0], source mask[2:0], ticks[11:0]}
  localparam logic [24:0] VEC [11] = '{
    {4'd0, 3'b001, 3'd0, 3'b001, 12'd5},
    {4'd1, 3'b010, 3'd1, 3'b010, 12'd9},
    {4'd2, 3'b100, 3'd2, 3'b100, 12'd40},
    {4'd3, 3'b110, 3'd1, 3'b100, 12'd12},
    {4'd4, 3'b011, 3'd0, 3'b001, 12'd4},
    {4'd5, 3'b000, 3'd0, 3'b111, 12'd6},
    {4'd8, 3'b001, 3'd3, 3'b001, 12'd130},
    {4'd9, 3'b010, 3'd4, 3'b010, 12'd600},
    {4'd6, 3'b100, 3'd6, 3'b100, 12'd1100},
    {4'd7, 3'b001, 3'd7, 3'b001, 12'd2100},
    {4'd7, 3'b001, 3'd5, 3'b001, 12'd1024}
  };

  function automatic int pos_of(input int ch);
    if (ch < 8) return ch;
    else if (ch == 8) return 15;
    else return 16;
  endfunction

  function automatic int exp_pulses(input logic [2:0] sel, input logic [2:0] ps,
                                    input logic [2:0] mask, input int ticks);
    int src;
    int div;
    if (sel[0]) src = 0; else if (sel[1]) src = 1; else if (sel[2]) src = 2; else return 0;
    if (!mask[src]) return 0;
    div = (ps >= 3'd5) ? 1024 : (1 << (2 * ps));
    return ticks / div;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // drive n source ticks on every cycle, count pulses on channel ch and elsewhere
  task automatic run_ticks(input int ch, input logic [2:0] mask, input int n,
                           output int hits, output int stray);
    hits = 0; stray = 0;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      for (int k = 0; k < NCH; k++)
        if (tick_out[k]) begin
          if (k == ch) hits++; else stray++;
        end
      {tick_ext, tick_rtc, tick_periph} = (i < n) ? mask : 3'b000;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    int hits, stray;
    n_checks = 0; n_fail = 0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    tick_periph = 1'b0; tick_rtc = 1'b0; tick_ext = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 tick_out", tick_out, 0);
    bus_read(0, rd);  check("R1 status", rd, 32'h180FF);
    bus_read(11, rd); check("R1 ctl ch3", rd, 0);

    // R4 control write gating
    bus_write(9, 32'h3F);
    bus_read(9, rd);  check("R4 ignored while stopped", rd, 0);
    bus_write(2, 32'h4);
    bus_write(10, 32'h1ABCD);
    bus_read(10, rd); check("R4 accepted 16 bits", rd, 32'hABCD);
    bus_write(1, 32'h4);
    bus_write(10, 32'h0);
    bus_read(10, rd); check("R4 stopped keeps value", rd, 32'hABCD);
    bus_write(2, 32'h4);
    bus_write(10, 32'h0);
    bus_read(10, rd); check("R4 rewrite when running", rd, 0);
    bus_write(1, 32'h4);

    // R2 / R3 / R9 stop flag set and clear
    bus_write(2, 32'h5);
    bus_read(0, rd);  check("R3 clear bits 0,2", rd, 32'h180FA);
    bus_write(1, 32'h1);
    bus_read(0, rd);  check("R2 set bit 0 only", rd, 32'h180FB);
    bus_write(2, 32'h7F00);
    bus_read(0, rd);  check("R9 unused positions", rd, 32'h180FB);
    bus_write(2, 32'h10000);
    bus_read(0, rd);  check("R9 watchdog at bit 16", rd, 32'h080FB);
    bus_write(1, 32'h1FFFF);
    bus_read(0, rd);  check("R2 set all", rd, 32'h180FF);
    bus_write(2, 32'h8000);
    bus_read(0, rd);  check("R9 OS timer at bit 15", rd, 32'h100FF);
    bus_write(1, 32'h8000);

    // R8 read latency and unmapped reads
    @(negedge clk); bus_addr = 5'd0;
    @(negedge clk); bus_addr = 5'd3;
    check("R8 status after one cycle", bus_rdata, 32'h180FF);
    @(negedge clk);
    check("R8 unmapped reads zero", bus_rdata, 0);
    bus_read(1, rd);  check("R8 set register reads zero", rd, 0);

    // R5 R6 R10 vector table
    foreach (VEC[v]) begin
      int ch;
      logic [2:0] sel, ps, mask;
      int nt;
      {ch, sel, ps, mask, nt} = {28'(VEC[v][24:21]), VEC[v][20:18], VEC[v][17:15],
                                 VEC[v][14:12], 20'd0, VEC[v][11:0]};
      ch = int'(VEC[v][24:21]);
      nt = int'(VEC[v][11:0]);
      bus_write(2, 32'(1) << pos_of(ch));
      bus_write(8 + ch, 32'({ps, sel}));
      run_ticks(ch, mask, nt, hits, stray);
      check($sformatf("R6 R5 vector %0d pulses", v), hits, exp_pulses(sel, ps, mask, nt));
      check($sformatf("R10 vector %0d stopped channels silent", v), stray, 0);
      bus_write(1, 32'(1) << pos_of(ch));
    end

    // R10 stopped channel with live source stays silent
    run_ticks(0, 3'b111, 8, hits, stray);
    check("R10 all stopped", hits + stray, 0);

    // R7 restart by stop/start
    bus_write(2, 32'h4);
    bus_write(10, 32'h9);
    run_ticks(2, 3'b001, 3, hits, stray);
    bus_write(1, 32'h4);
    bus_write(2, 32'h4);
    run_ticks(2, 3'b001, 3, hits, stray);
    check("R7 stop clears count", hits, 0);
    run_ticks(2, 3'b001, 1, hits, stray);
    check("R7 full ratio after stop", hits, 1);

    // R7 restart by control write
    run_ticks(2, 3'b001, 3, hits, stray);
    bus_write(10, 32'h9);
    run_ticks(2, 3'b001, 3, hits, stray);
    check("R7 control write clears count", hits, 0);
    run_ticks(2, 3'b001, 1, hits, stray);
    check("R7 full ratio after write", hits, 1);
    bus_write(1, 32'h4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule